// File: doc/BRIEF.md
# TDM Frame Timing Generator

This block produces the frame and slot timing for a time-division serial port. The port runs on a continuous bit clock, and each frame holds twelve slots of sixteen bits. On every bit clock the block presents the current slot number, the current bit number (most significant bit first) and a one-clock frame sync pulse. Serial data shifters elsewhere in the chip use these outputs to decide which sample word moves and which bit of it is on the line.

The frame rate can track a slower sample rate. A 3-bit rate code selects either the full rate, where a frame is exactly 192 bit clocks, or one of six slower rates. Each slower rate has a 16-bit fractional increment, supplied from configuration registers. A phase accumulator adds the increment of the selected rate on every bit clock. A frame ends at its 192nd clock, or at the first clock after that, once the accumulator has overflowed at least once since the frame began. While a frame is stretched, an idle flag is high and the slot and bit outputs hold. The number of idle clocks can therefore change from one frame to the next, and the average frame period is 65536/increment bit clocks.

Top module: `tdm_frame_timer`

## Requirements
- R1: While reset (active-low, synchronous) is held, and on the first clock after it is released, the outputs show slot 0, bit 15, idle flag low and frame sync low, and the full rate is selected. The first clock after release is the first bit of a frame.
- R2: With rate code 0 or 7 latched, every frame lasts exactly 192 bit clocks and the idle flag never rises.
- R3: Within a frame, the bit number counts down from 15 to 0, one step per clock. The slot number rises from 0 to 11, advancing after bit 0.
- R4: After slot 11 bit 0 of a stretched frame, the idle flag is high on each appended clock. During those clocks the slot output stays at 11 and the bit output stays at 0.
- R5: Frame sync is high for exactly one clock, the last clock of a frame. On the next clock the outputs show slot 0, bit 15, idle flag low.
- R6: Rate codes 1 to 6 use the 16-bit increment at bits [(code-1)*16 +: 16] of the increment bus. The accumulator adds this increment on every clock, keeps its value across frames, and holds while the full rate is latched. A frame ends on the first clock that is at or after its 192nd clock, provided an overflow has occurred on that clock or on any earlier clock of the same frame.
- R7: A frame never lasts fewer than 192 clocks, even when the increment overflows on almost every clock (for example 16'hFFFF).
- R8: A change on the rate code takes effect only at a frame boundary. The frame in progress when the code changes keeps the rate it began with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| rate_sel_i | input | 3 | Frame-rate code: 0 and 7 select the full rate, 1 to 6 select a slow rate |
| rate_inc_i | input | 96 | Six 16-bit fractional increments; the increment for code c is at bits [(c-1)*16 +: 16] |
| fsync_o | output | 1 | Frame sync, high on the last clock of each frame |
| slot_o | output | 4 | Current slot number, 0 to 11 |
| bit_o | output | 4 | Current bit number within the slot, 15 down to 0 |
| pad_o | output | 1 | High on idle clocks appended after the last slot |

## Verification
The hardest case to reach from the ports is a frame whose length depends on an accumulator value left over from earlier frames, and a rate-code change that arrives in the middle of such a frame. The bench keeps its own accumulator value across frames. For each frame it computes the expected length from the increment arithmetic and queues it. The rate code is changed about twenty clocks into a frame, so the frame in progress must still end with its old length. The rates tested include an exact divisor (256, giving 256-clock frames), a fractional one (327, giving frames of 200 or 201 clocks), a near-maximum increment that must stay at 192 clocks, and the alternate full-rate code 7.

// File: rtl/tdm_timer_pkg.sv
// Package: tdm_timer_pkg
// Shared constants and the rate-code encoding for the TDM frame timing generator.
// Assumes a 3-bit rate code in which code 0 and codes above the number of slow rates select the full rate.
package tdm_timer_pkg;

    localparam int RATE_SEL_W = 3;

    typedef enum logic [RATE_SEL_W-1:0] {
        RATE_FULL     = 3'd0,
        RATE_MODEM    = 3'd1,
        RATE_CAPTURE  = 3'd2,
        RATE_PLAYBACK = 3'd3,
        RATE_SYNTH    = 3'd4,
        RATE_SERIAL1  = 3'd5,
        RATE_SERIAL0  = 3'd6,
        RATE_FULL_ALT = 3'd7
    } rate_code_e;

endpackage

// File: rtl/tdm_rate_select.sv
// Module: tdm_rate_select
// Latches the rate code at each frame boundary and selects that rate's fractional increment.
// Assumes frame_end_i is high on the last clock of a frame. The code is captured there and used for the next frame.
module tdm_rate_select
    import tdm_timer_pkg::*;
#(
    parameter int ACC_W    = 16,
    parameter int NUM_SLOW = 6
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      frame_end_i,
    input  logic [RATE_SEL_W-1:0]     rate_sel_i,
    input  logic [NUM_SLOW*ACC_W-1:0] rate_inc_i,
    output logic [RATE_SEL_W-1:0]     sel_q_o,
    output logic                      full_rate_o,
    output logic [ACC_W-1:0]          inc_o
);

    logic [RATE_SEL_W-1:0] sel_q;

    // Capture a new rate code only at a frame boundary; reset selects the full rate.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sel_q <= RATE_FULL;
        end else if (frame_end_i) begin
            sel_q <= rate_sel_i;
        end
    end

    // Pick the increment that belongs to the latched slow-rate code.
    always_comb begin
        inc_o = '0;
        for (int i = 0; i < NUM_SLOW; i++) begin
            if (sel_q == RATE_SEL_W'(i + 1)) begin
                inc_o = rate_inc_i[i*ACC_W +: ACC_W];
            end
        end
    end

    // Code 0, and any code beyond the slow rates, runs at the full rate.
    assign full_rate_o = (sel_q == RATE_FULL) || (int'(sel_q) > NUM_SLOW);
    assign sel_q_o     = sel_q;

endmodule

// File: rtl/tdm_phase_acc.sv
// Module: tdm_phase_acc
// A fractional phase accumulator. It reports whether an overflow has occurred since the current frame began.
// Assumes the accumulator keeps its value across frames and holds while the full rate is latched.
module tdm_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             full_rate_i,
    input  logic [ACC_W-1:0] inc_i,
    input  logic             frame_end_i,
    output logic             ready_o
);

    logic [ACC_W-1:0] acc_q;
    logic             pending_q;
    logic [ACC_W:0]   sum;
    logic             carry;

    // Add the increment with one extra bit; the top bit is the overflow.
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, inc_i};
        carry = !full_rate_i && sum[ACC_W];
    end

    assign ready_o = pending_q || carry;

    // Advance the phase on every clock of a slow-rate frame.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (!full_rate_i) begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

    // Remember an overflow until the frame it released has ended.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pending_q <= 1'b0;
        end else if (frame_end_i) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= ready_o;
        end
    end

endmodule

// File: rtl/tdm_slot_counter.sv
// Module: tdm_slot_counter
// Tracks the position within a frame: a down-counting bit index, an up-counting slot index and an idle flag.
// Assumes frame_end_i is raised only while last_o is high. It then restarts the frame at slot 0, bit MSB.
module tdm_slot_counter #(
    parameter int BITS_PER_SLOT   = 16,
    parameter int SLOTS_PER_FRAME = 12,
    parameter int BIT_W           = $clog2(BITS_PER_SLOT),
    parameter int SLOT_W          = $clog2(SLOTS_PER_FRAME)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_end_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic              pad_o,
    output logic              last_o
);

    localparam logic [BIT_W-1:0]  BIT_MSB   = BIT_W'(BITS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS_PER_FRAME - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic              pad_q;

    // The frame may end on the final bit of the last slot or on any idle clock.
    assign last_o = pad_q || ((slot_q == SLOT_LAST) && (bit_q == '0));

    // Step through the bits and slots, then hold while idle clocks are appended.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || frame_end_i) begin
            slot_q <= '0;
            bit_q  <= BIT_MSB;
            pad_q  <= 1'b0;
        end else if (pad_q) begin
            slot_q <= slot_q;
            bit_q  <= bit_q;
        end else if (bit_q == '0) begin
            if (slot_q == SLOT_LAST) begin
                pad_q <= 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
                bit_q  <= BIT_MSB;
            end
        end else begin
            bit_q <= bit_q - 1'b1;
        end
    end

    assign slot_o = slot_q;
    assign bit_o  = bit_q;
    assign pad_o  = pad_q;

endmodule

// File: rtl/tdm_frame_timer.sv
// Module: tdm_frame_timer
// Top level of the TDM frame timing generator. It produces the frame sync, slot and bit indices and the idle flag,
// and it stretches frames to an average length of 65536/increment clocks when a slow rate is latched.
// Assumes a continuous bit clock and a synchronous active-low reset.
module tdm_frame_timer
    import tdm_timer_pkg::*;
#(
    parameter int BITS_PER_SLOT   = 16,
    parameter int SLOTS_PER_FRAME = 12,
    parameter int ACC_W           = 16,
    parameter int NUM_SLOW        = 6
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic [RATE_SEL_W-1:0]                rate_sel_i,
    input  logic [NUM_SLOW*ACC_W-1:0]            rate_inc_i,
    output logic                                 fsync_o,
    output logic [$clog2(SLOTS_PER_FRAME)-1:0]   slot_o,
    output logic [$clog2(BITS_PER_SLOT)-1:0]     bit_o,
    output logic                                 pad_o
);

    localparam int BIT_W  = $clog2(BITS_PER_SLOT);
    localparam int SLOT_W = $clog2(SLOTS_PER_FRAME);

    logic                  frame_end;
    logic                  full_rate;
    logic                  ready;
    logic                  last_clk;
    logic [ACC_W-1:0]      inc;
    logic [RATE_SEL_W-1:0] sel_latched;

    tdm_rate_select #(
        .ACC_W    (ACC_W),
        .NUM_SLOW (NUM_SLOW)
    ) u_rate_select (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .frame_end_i (frame_end),
        .rate_sel_i  (rate_sel_i),
        .rate_inc_i  (rate_inc_i),
        .sel_q_o     (sel_latched),
        .full_rate_o (full_rate),
        .inc_o       (inc)
    );

    tdm_phase_acc #(
        .ACC_W (ACC_W)
    ) u_phase_acc (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .full_rate_i (full_rate),
        .inc_i       (inc),
        .frame_end_i (frame_end),
        .ready_o     (ready)
    );

    tdm_slot_counter #(
        .BITS_PER_SLOT   (BITS_PER_SLOT),
        .SLOTS_PER_FRAME (SLOTS_PER_FRAME),
        .BIT_W           (BIT_W),
        .SLOT_W          (SLOT_W)
    ) u_slot_counter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .frame_end_i (frame_end),
        .slot_o      (slot_o),
        .bit_o       (bit_o),
        .pad_o       (pad_o),
        .last_o      (last_clk)
    );

    // A frame closes on an eligible last clock once the rate allows it.
    assign frame_end = rst_ni && last_clk && (full_rate || ready);
    assign fsync_o   = frame_end;

endmodule

// File: rtl/tdm_frame_timer_chk.sv
// Module: tdm_frame_timer_chk
// Property checker for tdm_frame_timer, attached to it with the bind statement below.
// Assumes the latched rate code is visible as sel_q_i.
module tdm_frame_timer_chk #(
    parameter int SLOT_W = 4,
    parameter int BIT_W  = 4,
    parameter int SLOTS  = 12,
    parameter int BITS   = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              fsync_i,
    input logic [SLOT_W-1:0] slot_i,
    input logic [BIT_W-1:0]  bit_i,
    input logic              pad_i,
    input logic [2:0]        sel_q_i
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);
    localparam logic [BIT_W-1:0]  MSB  = BIT_W'(BITS - 1);

    // R5: sync lasts a single clock
    a_r5_sync_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsync_i |=> !fsync_i);

    // R5: the clock after sync is slot 0, bit MSB, not idle
    a_r5_sync_starts_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsync_i |=> (slot_i == '0) && (bit_i == MSB) && !pad_i);

    // R3: the bit index steps down by one
    a_r3_bit_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pad_i && !fsync_i && (bit_i != '0)) |=> (bit_i == $past(bit_i) - 1'b1));

    // R4: slot and bit hold across idle clocks
    a_r4_pad_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_i && !fsync_i) |=> pad_i && $stable(slot_i) && $stable(bit_i));

    // R4: idle clocks follow only the last bit of the last slot
    a_r4_pad_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pad_i) |-> ($past(slot_i) == LAST) && ($past(bit_i) == '0));

    // R8: the latched rate code changes only at a frame boundary
    a_r8_rate_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fsync_i |=> $stable(sel_q_i));

    // R2: the full rate never appends idle clocks
    a_r2_full_no_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sel_q_i == 3'd0) || (sel_q_i == 3'd7)) |-> !pad_i);

endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(
    .SLOT_W (SLOT_W),
    .BIT_W  (BIT_W),
    .SLOTS  (SLOTS_PER_FRAME),
    .BITS   (BITS_PER_SLOT)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_o),
    .slot_i  (slot_o),
    .bit_i   (bit_o),
    .pad_i   (pad_o),
    .sel_q_i (sel_latched)
);

// File: tb/tdm_frame_timer_bench.sv
// Scoreboard bench: the driver computes the expected frame lengths and queues them.
// The monitor measures each frame, checks the slot, bit and idle sequence, and compares the length.
module tdm_frame_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rate_sel = 3'd0;
    logic [95:0] rate_inc;
    logic        fsync;
    logic [3:0]  slot;
    logic [3:0]  bitn;
    logic        pad;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    int pushed = 0;
    int frames_done = 0;
    bit run = 1'b0;
    bit done = 1'b0;
    longint m_acc = 0;
    int incs[8];

    always #10 clk = ~clk;

    tdm_frame_timer u_tdm_frame_timer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rate_sel_i (rate_sel),
        .rate_inc_i (rate_inc),
        .fsync_o    (fsync),
        .slot_o     (slot),
        .bit_o      (bitn),
        .pad_o      (pad)
    );

    // R6/R7: expected frame length from the increment arithmetic, with the accumulator kept across frames
    function automatic int model_len(int sel);
        longint a;
        bit     carry;
        if (sel == 0 || sel == 7) return 192;
        a = m_acc;
        carry = 1'b0;
        for (int k = 0; k < 100000; k++) begin
            a = a + incs[sel];
            if (a >= 65536) begin
                a = a - 65536;
                carry = 1'b1;
            end
            if (k >= 191 && carry) begin
                m_acc = a;
                return k + 1;
            end
        end
        return -1;
    endfunction

    task automatic push_frames(int sel, int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model_len(sel));
            pushed++;
        end
    endtask

    // R8: change the code mid-frame; the frame in progress keeps its old length
    task automatic phase(int sel, int n);
        rate_sel = 3'(sel);
        push_frames(sel, n);
        wait (frames_done >= pushed - 1);
        repeat (20) @(negedge clk);
    endtask

    // Monitor: position checks on each clock, length compare on each sync
    int  cnt = 0;
    bit  frame_bad = 1'b0;
    int  bad_pos = 0;
    always @(negedge clk) begin
        if (run) begin
            int es, eb;
            bit ep;
            es = (cnt < 192) ? cnt / 16 : 11;
            eb = (cnt < 192) ? 15 - (cnt % 16) : 0;
            ep = (cnt >= 192);
            if (!frame_bad && (int'(slot) != es || int'(bitn) != eb || pad != ep)) begin
                frame_bad = 1'b1;
                bad_pos = cnt;
                $display("FAIL R3/R4 pos %0d: slot=%0d bit=%0d pad=%0d expected slot=%0d bit=%0d pad=%0d",
                         cnt, slot, bitn, pad, es, eb, ep);
            end
            if (fsync) begin
                int exp_len;
                exp_len = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                checks++;
                if (cnt + 1 != exp_len) begin
                    fails++;
                    $display("FAIL R5/R6 frame %0d length: actual %0d expected %0d", frames_done, cnt + 1, exp_len);
                end
                checks++;   // R3 R4 sequence within the frame
                if (frame_bad) fails++;
                frame_bad = 1'b0;
                cnt = 0;
                frames_done++;
            end else begin
                cnt++;
            end
        end
    end

    // Driver
    initial begin
        incs = '{0, 256, 327, 65535, 300, 400, 500, 0};
        rate_inc = {16'd500, 16'd400, 16'd300, 16'hFFFF, 16'd327, 16'd256};
        repeat (3) @(posedge clk);
        // R1: reset state
        @(negedge clk);
        checks++;
        if (slot != 4'd0 || bitn != 4'd15 || pad != 1'b0 || fsync != 1'b0) begin
            fails++;
            $display("FAIL R1 reset: slot=%0d bit=%0d pad=%0d fsync=%0d expected 0 15 0 0", slot, bitn, pad, fsync);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        run = 1'b1;
        push_frames(0, 1);        // R1: first frame starts at once, full rate
        repeat (20) @(negedge clk);
        phase(0, 2);              // R2: full rate
        phase(1, 3);              // R6: exact 256-clock frames
        phase(2, 5);              // R6: fractional, 200 or 201 clocks
        phase(7, 2);              // R2: alternate full-rate code
        phase(3, 2);              // R7: near-maximum increment stays at 192
        phase(0, 2);              // R8: back to full rate at the boundary
        wait (frames_done == pushed);
        run = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog: frames_done=%0d expected %0d", frames_done, pushed);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule